// File: doc/BRIEF.md
# Three-Line Monitor Sense Prober

This block identifies an attached display by probing three open-drain sense wires, called A, B and C. After a start pulse it runs a fixed sequence. First it drives all three wires high for a short precharge interval. It then releases every driver, waits a longer settle interval and samples all three wires. Next it pulls one wire low at a time, in the order A, B, C. Each of these steps waits the settle interval and then samples the two wires it is not driving. At the end it releases all drivers and raises a done flag. An 11-bit code sits beside the done flag.

The wire levels come in on `sense_in_i` and pass through a synchronizer before they are sampled. Software-free callers program the two interval lengths in clock cycles through `precharge_len_i` and `settle_len_i`. A length of zero is treated as one cycle. The settle length must be at least `SYNC_STAGES + 1`, so that a level set up in a step reaches the sampling point within that same step. Turning the code into a display mode is left to the consumer of `code_o`.

Top module: `monitor_sense_prober`

## Requirements
- R1: A start pulse seen while idle or done begins a run. From the clock edge that takes the start, `busy_o` is high for exactly P + 4·S cycles, where P is max(precharge_len_i, 1) and S is max(settle_len_i, 1). In the cycle after that, `done_o` rises.
- R2: During the first P cycles of a run, all three output-enable bits and all three output-value bits are 1.
- R3: In the next S cycles every output enable is 0. At the end of this step, wire A is captured into code bit 10, wire B into bit 9 and wire C into bit 8.
- R4: In the next S cycles only wire A is driven low (enable pattern 3'b001, values 3'b000). At the end of this step, B is captured into code bit 5 and C into bit 4.
- R5: In the next S cycles only wire B is driven low (enable 3'b010, values 3'b000). At the end of this step, A is captured into code bit 3 and C into bit 2.
- R6: In the next S cycles only wire C is driven low (enable 3'b100, values 3'b000). At the end of this step, A is captured into code bit 1 and B into bit 0.
- R7: Code bits 7 and 6 are always 0. While done, all output enables and output values are 0.
- R8: A start pulse that arrives while busy has no effect. The run keeps its timing and its code.
- R9: `done_o` and `code_o` hold their values until the next accepted start. That start clears `done_o` and the whole code in the first cycle of the new run.
- R10: After reset, `busy_o`, `done_o`, every enable, every output value and the code are all 0.

Bit index 0, 1 and 2 of `sense_oe_o`, `sense_out_o` and `sense_in_i` stand for wires A, B and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request pulse |
| precharge_len_i | input | CNT_W | Length of the drive-high step in cycles |
| settle_len_i | input | CNT_W | Length of each settle step in cycles |
| sense_in_i | input | 3 | Levels on wires A, B, C |
| sense_oe_o | output | 3 | Output enable per wire |
| sense_out_o | output | 3 | Driven level per wire |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, code valid |
| code_o | output | 11 | Sense code |

## Verification
The hardest case to reach from the ports is a start that arrives in the middle of a pull-low step. It must neither restart the run nor disturb the code that has already been captured. The bench models the display as a set of resistive straps, where each wire may be grounded or tied to another wire. This model makes the wire levels react to the block's own drivers. The bench then injects a second start pulse partway through a run and checks every cycle's drive pattern against the timeline of an undisturbed run. Different strap sets give different codes. The bench also exercises precharge length zero and two runs issued back to back.

// File: rtl/sense_pkg.sv
package sense_pkg;
  localparam int NLINES = 3;
  localparam int CODE_W = 11;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DRIVE  = 3'd1,
    PH_REL    = 3'd2,
    PH_PULL_A = 3'd3,
    PH_PULL_B = 3'd4,
    PH_PULL_C = 3'd5,
    PH_DONE   = 3'd6
  } phase_e;
endpackage

// File: rtl/sense_sync.sv
module sense_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= '0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sense_timer.sv
module sense_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    if (load_i) cnt_d = (len_i == '0) ? '0 : len_i - 1'b1;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == '0);

  a_r1_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/sense_fsm.sv
module sense_fsm
  import sense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              expire_i,
  output logic              load_o,
  output logic              long_o,
  output logic              sample_o,
  output logic              clear_o,
  output phase_e            phase_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [NLINES-1:0] oe_o,
  output logic [NLINES-1:0] out_o
);
  phase_e            phase_q, phase_d;
  logic              adv;
  logic [NLINES-1:0] oe_q, oe_d, out_q, out_d;
  logic              busy_q, busy_d, done_q, done_d;

  always_comb begin
    phase_d  = phase_q;
    load_o   = 1'b0;
    long_o   = 1'b1;
    sample_o = 1'b0;
    clear_o  = 1'b0;
    unique case (phase_q)
      PH_IDLE, PH_DONE: if (start_i) begin
        phase_d = PH_DRIVE;
        load_o  = 1'b1;
        long_o  = 1'b0;
        clear_o = 1'b1;
      end
      PH_DRIVE: if (expire_i) begin
        phase_d = PH_REL;
        load_o  = 1'b1;
      end
      PH_REL: if (expire_i) begin
        phase_d  = PH_PULL_A;
        load_o   = 1'b1;
        sample_o = 1'b1;
      end
      PH_PULL_A: if (expire_i) begin
        phase_d  = PH_PULL_B;
        load_o   = 1'b1;
        sample_o = 1'b1;
      end
      PH_PULL_B: if (expire_i) begin
        phase_d  = PH_PULL_C;
        load_o   = 1'b1;
        sample_o = 1'b1;
      end
      PH_PULL_C: if (expire_i) begin
        phase_d  = PH_DONE;
        sample_o = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
    adv = (phase_d != phase_q);
  end

  always_comb begin
    oe_d   = '0;
    out_d  = '0;
    busy_d = 1'b1;
    done_d = 1'b0;
    case (phase_d)
      PH_DRIVE:  begin oe_d = '1; out_d = '1; end
      PH_REL:    oe_d = '0;
      PH_PULL_A: oe_d = 3'b001;
      PH_PULL_B: oe_d = 3'b010;
      PH_PULL_C: oe_d = 3'b100;
      PH_DONE:   begin busy_d = 1'b0; done_d = 1'b1; end
      default:   busy_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      oe_q    <= '0;
      out_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (adv) begin
      phase_q <= phase_d;
      oe_q    <= oe_d;
      out_q   <= out_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign oe_o    = oe_q;
  assign out_o   = out_q;

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q != PH_DRIVE && start_i) |=> (phase_q != PH_DRIVE));
  a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);
  a_r7_released_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (oe_q == '0 && out_q == '0));
  a_r2_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DRIVE) |-> (oe_q == '1 && out_q == '1));
  a_r4_single_low: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q inside {PH_PULL_A, PH_PULL_B, PH_PULL_C}) |-> ($onehot0(oe_q) && $countones(oe_q) == 1 && out_q == '0));
endmodule

// File: rtl/sense_pack.sv
module sense_pack
  import sense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  phase_e            phase_i,
  input  logic [NLINES-1:0] lines_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q, code_d;
  logic              code_en;
  logic              wa, wb, wc;

  assign wa = lines_i[0];
  assign wb = lines_i[1];
  assign wc = lines_i[2];

  always_comb begin
    code_d  = code_q;
    code_en = clear_i || sample_i;
    if (clear_i) begin
      code_d = '0;
    end else if (sample_i) begin
      case (phase_i)
        PH_REL:    code_d[10:8] = {wa, wb, wc};
        PH_PULL_A: code_d[5:4]  = {wb, wc};
        PH_PULL_B: code_d[3:2]  = {wa, wc};
        PH_PULL_C: code_d[1:0]  = {wa, wb};
        default:   code_d       = code_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;

  a_r9_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !sample_i) |=> $stable(code_q));
  a_r7_gap_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    code_q[7:6] == 2'b00);
endmodule

// File: rtl/monitor_sense_prober.sv
module monitor_sense_prober
  import sense_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  precharge_len_i,
  input  logic [CNT_W-1:0]  settle_len_i,
  input  logic [2:0]        sense_in_i,
  output logic [2:0]        sense_oe_o,
  output logic [2:0]        sense_out_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [10:0]       code_o
);
  logic [NLINES-1:0] lines_s;
  logic              load, long_sel, sample, clear, expire;
  logic [CNT_W-1:0]  len_mux;
  phase_e            phase;

  sense_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(sense_in_i), .sync_o(lines_s)
  );

  assign len_mux = long_sel ? settle_len_i : precharge_len_i;

  sense_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(load), .len_i(len_mux), .expire_o(expire)
  );

  sense_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .expire_i(expire),
    .load_o(load), .long_o(long_sel), .sample_o(sample), .clear_o(clear),
    .phase_o(phase), .busy_o(busy_o), .done_o(done_o),
    .oe_o(sense_oe_o), .out_o(sense_out_o)
  );

  sense_pack u_pack (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .sample_i(sample),
    .phase_i(phase), .lines_i(lines_s), .code_o(code_o)
  );

  a_r1_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && done_o));
  a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o));
endmodule

// File: tb/monitor_sense_prober_tb.sv
module monitor_sense_prober_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start_i;
  logic [CNT_W-1:0] pre_len, set_len;
  logic [2:0] lv, oe, outv;
  logic busy, done;
  logic [10:0] code;

  logic [2:0] gnd;   // per-wire strap to ground
  logic [2:0] lk;    // bit0 A-B, bit1 B-C, bit2 A-C
  int nchecks = 0, nfail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  monitor_sense_prober #(.CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .precharge_len_i(pre_len), .settle_len_i(set_len),
    .sense_in_i(lv), .sense_oe_o(oe), .sense_out_o(outv),
    .busy_o(busy), .done_o(done), .code_o(code)
  );

  function automatic bit linked(int i, int j);
    if ((i == 0 && j == 1) || (i == 1 && j == 0)) return lk[0];
    if ((i == 1 && j == 2) || (i == 2 && j == 1)) return lk[1];
    if ((i == 0 && j == 2) || (i == 2 && j == 0)) return lk[2];
    return 1'b0;
  endfunction

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      if (oe[i]) lv[i] = outv[i];
      else begin
        logic pd;
        pd = gnd[i];
        for (int j = 0; j < 3; j++)
          if (j != i && oe[j] && !outv[j] && linked(i, j)) pd = 1'b1;
        lv[i] = !pd;
      end
    end
  end

  function automatic logic lvl(int i, int p);
    return !(gnd[i] || (p >= 0 && linked(i, p)));
  endfunction

  function automatic logic [10:0] exp_code();
    logic [10:0] c;
    c = '0;
    c[10] = lvl(0, -1); c[9] = lvl(1, -1); c[8] = lvl(2, -1);
    c[5] = lvl(1, 0); c[4] = lvl(2, 0);
    c[3] = lvl(0, 1); c[2] = lvl(2, 1);
    c[1] = lvl(0, 2); c[0] = lvl(1, 2);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One full run; mid>0 injects an extra start pulse at that cycle.
  task automatic run_seq(input int d, input int s, input int mid, input string tag);
    int dd, total, e_drv, e_rel, e_a, e_b, e_c, e_busy, e_end;
    logic [10:0] ec;
    dd = (d == 0) ? 1 : d;
    total = dd + 4 * s;
    e_drv = 0; e_rel = 0; e_a = 0; e_b = 0; e_c = 0; e_busy = 0; e_end = 0;
    ec = exp_code();
    @(negedge clk);
    pre_len = CNT_W'(d); set_len = CNT_W'(s);
    start_i = 1'b1;
    for (int n = 1; n <= total + 1; n++) begin
      @(negedge clk);
      start_i = (n == mid);
      if (n == 1) begin
        check(done == 1'b0, {"R9 done cleared ", tag}, done, 0);
        check(code == 11'd0, {"R9 code cleared ", tag}, code, 0);
      end
      if (n <= total) begin
        if (busy !== 1'b1 || done !== 1'b0) e_busy++;
      end
      if (n <= dd) begin
        if (oe !== 3'b111 || outv !== 3'b111) e_drv++;
      end else if (n <= dd + s) begin
        if (oe !== 3'b000) e_rel++;
      end else if (n <= dd + 2*s) begin
        if (oe !== 3'b001 || outv !== 3'b000) e_a++;
      end else if (n <= dd + 3*s) begin
        if (oe !== 3'b010 || outv !== 3'b000) e_b++;
      end else if (n <= total) begin
        if (oe !== 3'b100 || outv !== 3'b000) e_c++;
      end else begin
        if (oe !== 3'b000 || outv !== 3'b000) e_end++;
      end
    end
    start_i = 1'b0;
    check(e_busy == 0, {"R1 busy window ", tag}, e_busy, 0);
    check(busy == 1'b0 && done == 1'b1, {"R1 done rises on time ", tag}, {busy, done}, 1);
    check(e_drv == 0, {"R2 precharge pattern ", tag}, e_drv, 0);
    check(e_rel == 0, {"R3 release pattern ", tag}, e_rel, 0);
    check(e_a == 0, {"R4 A-low pattern ", tag}, e_a, 0);
    check(e_b == 0, {"R5 B-low pattern ", tag}, e_b, 0);
    check(e_c == 0, {"R6 C-low pattern ", tag}, e_c, 0);
    check(e_end == 0, {"R7 released when done ", tag}, e_end, 0);
    check(code[10:8] == ec[10:8], {"R3 code[10:8] ", tag}, code[10:8], ec[10:8]);
    check(code[5:4] == ec[5:4], {"R4 code[5:4] ", tag}, code[5:4], ec[5:4]);
    check(code[3:2] == ec[3:2], {"R5 code[3:2] ", tag}, code[3:2], ec[3:2]);
    check(code[1:0] == ec[1:0], {"R6 code[1:0] ", tag}, code[1:0], ec[1:0]);
    check(code[7:6] == 2'b00, {"R7 gap bits ", tag}, code[7:6], 0);
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0, "R10 busy/done after reset", {busy, done}, 0);
    check(oe == 0 && outv == 0, "R10 drivers after reset", {oe, outv}, 0);
    check(code == 0, "R10 code after reset", code, 0);
  endtask

  task automatic t_open_display();
    gnd = 3'b000; lk = 3'b000;
    run_seq(3, 6, 0, "open");
    check(code == 11'h73F, "R3 open code value", code, 11'h73F);
  endtask

  task automatic t_zero_precharge();
    gnd = 3'b010; lk = 3'b100;
    run_seq(0, 4, 0, "zero-precharge");
  endtask

  task automatic t_all_linked();
    gnd = 3'b000; lk = 3'b111;
    run_seq(2, 5, 0, "all-linked");
    check(code == 11'h700, "R4 all-linked code value", code, 11'h700);
  endtask

  task automatic t_start_while_busy();
    gnd = 3'b100; lk = 3'b001;
    run_seq(4, 5, 12, "R8 mid-start");
  endtask

  task automatic t_done_hold();
    logic [10:0] held;
    held = code;
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R9 done held", done, 1);
    check(code == held, "R9 code held", code, held);
    gnd = 3'b001; lk = 3'b010;
    run_seq(1, 4, 0, "R9 back-to-back");
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nchecks++;
      nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up();
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; pre_len = '0; set_len = '0;
    gnd = '0; lk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_open_display();
    t_zero_precharge();
    t_all_linked();
    t_start_while_busy();
    t_done_hold();
    finished = 1;
    finish_up();
  end
endmodule